// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block receives asynchronous serial frames that carry one extra bit after the data byte. That bit marks a frame as an address (ID) frame rather than an ordinary data frame. Several stations can share one serial line. Each station keeps a wake-up enable flag set while the traffic is meant for another station. With the flag set, the receiver drops every data frame without disturbing the host. When an ID frame arrives, the receiver delivers it and clears the wake-up flag by itself. The host then compares the ID with its own. If the ID matches, the following data frames arrive normally. If it does not match, the host sets the wake-up flag again and the receiver goes back to ignoring the line.

The serial input first passes through a two-stage synchronizer. An external tick runs at sixteen times the bit rate, and each bit is sampled at its centre on that tick. The host side is a set of register-style outputs: the received byte, the address bit of the last delivered frame, a receive-full flag, the wake-up flag and two sticky error flags. Single-cycle strobes from the host clear or set these flags. A one-cycle interrupt pulse marks each delivery into the data register.

Top module: `mpu_rx_top`

## Requirements
- R1: A frame is one low start bit, then 8 data bits with bit 0 first, then one address bit, then one stop bit. A delivered frame's byte appears on `rx_data_o`, with bit 0 being the first data bit received.
- R2: The line idles high. A falling edge whose level is no longer low at the middle of the start bit is discarded. It changes no output, and the receiver stays ready for the next start bit.
- R3: While `wake_en_o` is 1, a frame whose address bit is 0 is dropped. `rx_data_o`, `rx_mpb_o`, `rx_full_o` and both error flags keep their values, and no interrupt pulse occurs.
- R4: While `wake_en_o` is 1, a frame whose address bit is 1 is delivered. Its byte is loaded, `rx_full_o` becomes 1 and `rx_irq_o` pulses high for exactly one cycle.
- R5: Delivering a frame whose address bit is 1 clears `wake_en_o` to 0.
- R6: While `wake_en_o` is 0, every frame is delivered whatever its address bit is. `rx_mpb_o` shows the address bit of the last frame loaded into the data register.
- R7: A one-cycle `full_clr_i` clears `rx_full_o`. A one-cycle `wake_set_i` sets `wake_en_o`. If the hardware clears the wake-up flag in the same cycle as `wake_set_i`, the set wins.
- R8: If a frame is due for delivery while `rx_full_o` is 1, `overrun_o` becomes 1. In that case `rx_data_o` and `rx_mpb_o` are not changed and no interrupt pulse occurs.
- R9: A delivered frame whose stop bit samples low sets `frame_err_o`, and its byte is still delivered. Both error flags stay set until `err_clr_i` is pulsed.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial line, asynchronous |
| tick_i | input | 1 | One-cycle strobe at 16x the bit rate |
| wake_set_i | input | 1 | Host strobe that sets the wake-up enable flag |
| full_clr_i | input | 1 | Host strobe that clears the receive-full flag |
| err_clr_i | input | 1 | Host strobe that clears both error flags |
| rx_data_o | output | 8 | Last delivered byte |
| rx_mpb_o | output | 1 | Address bit of the last delivered frame |
| rx_full_o | output | 1 | Receive-full flag |
| wake_en_o | output | 1 | Wake-up enable flag |
| frame_err_o | output | 1 | Sticky framing-error flag |
| overrun_o | output | 1 | Sticky overrun flag |
| rx_irq_o | output | 1 | One-cycle pulse on each delivery |

## Verification
A wrong sample point or bit count inside the framer shows up as a wrong byte, a wrong address bit or a false framing error. It becomes visible at the ports a few cycles after the middle of the stop bit of the frame it affected. A wrong wake-up flag is visible at once on `wake_en_o`. Its effect shows up one frame later, when a data frame raises an interrupt it should not, or when an ID frame is lost. Overrun and drop mistakes show up as an unexpected change of the data register or of the interrupt count. The bench checks both after every frame.

// File: rtl/mpu_rx_pkg.sv
// Shared definitions for the address-filtering serial receiver.
package mpu_rx_pkg;
    // Number of data bits in every frame.
    parameter int DATA_W = 8;

    // Framer states, in the order they are visited for one frame.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ADDR,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/mpu_rx_sync.sv
// Multi-stage synchronizer for the asynchronous serial line.
// Assumes the line idles high, so every stage resets to 1.
module mpu_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mpu_rx_framer.sv
// Frame receiver. It detects a start bit, checks it again at mid-bit,
// samples DATA_W data bits, one address bit and the stop bit at their
// centres, and emits a one-cycle frame strobe.
// Assumes tick_i pulses at OVS times the bit rate and rx_i is synchronized.
module mpu_rx_framer
    import mpu_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    output logic              frm_valid_o,
    output logic [DATA_W-1:0] frm_data_o,
    output logic              frm_addr_o,
    output logic              frm_stop_ok_o
);
    localparam int CW   = $clog2(OVS);
    localparam int IW   = $clog2(DATA_W + 1);
    localparam int HALF = OVS / 2;

    rx_state_e         state_q;
    logic [CW-1:0]     tcnt_q;
    logic [IW-1:0]     bidx_q;
    logic [DATA_W-1:0] shift_q;
    logic              addr_q;
    logic              at_centre;

    assign at_centre = (tcnt_q == CW'(OVS - 1));

    // Step the frame state machine once per oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            tcnt_q        <= '0;
            bidx_q        <= '0;
            shift_q       <= '0;
            addr_q        <= 1'b0;
            frm_valid_o   <= 1'b0;
            frm_stop_ok_o <= 1'b0;
        end else begin
            frm_valid_o <= 1'b0;
            if (tick_i) begin
                case (state_q)
                    ST_IDLE: begin
                        if (!rx_i) begin
                            state_q <= ST_START;
                            tcnt_q  <= '0;
                        end
                    end
                    ST_START: begin
                        if (tcnt_q == CW'(HALF - 1)) begin
                            tcnt_q <= '0;
                            bidx_q <= '0;
                            state_q <= rx_i ? ST_IDLE : ST_DATA;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_centre) begin
                            tcnt_q  <= '0;
                            shift_q <= {rx_i, shift_q[DATA_W-1:1]};
                            if (bidx_q == IW'(DATA_W - 1)) state_q <= ST_ADDR;
                            else                            bidx_q  <= bidx_q + 1'b1;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        if (at_centre) begin
                            tcnt_q  <= '0;
                            addr_q  <= rx_i;
                            state_q <= ST_STOP;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_centre) begin
                            tcnt_q        <= '0;
                            frm_valid_o   <= 1'b1;
                            frm_stop_ok_o <= rx_i;
                            state_q       <= ST_IDLE;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign frm_data_o = shift_q;
    assign frm_addr_o = addr_q;

    // R1: the data-bit index never runs past the last data bit.
    assert_bidx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (bidx_q < IW'(DATA_W)));

    // R1: a frame strobe lasts one cycle and leaves the framer idle.
    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid_o |-> (state_q == ST_IDLE) ##1 !frm_valid_o);
endmodule

// File: rtl/mpu_rx_regs.sv
// Host-side registers. This module applies the wake-up address filter to
// each received frame, loads the data register, keeps the full flag,
// the sticky error flags and the interrupt pulse.
// Assumes frm_valid_i is a one-cycle strobe and that its data stays stable with it.
module mpu_rx_regs
    import mpu_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid_i,
    input  logic [DATA_W-1:0] frm_data_i,
    input  logic              frm_addr_i,
    input  logic              frm_stop_ok_i,
    input  logic              wake_set_i,
    input  logic              full_clr_i,
    input  logic              err_clr_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_mpb_o,
    output logic              rx_full_o,
    output logic              wake_en_o,
    output logic              frame_err_o,
    output logic              overrun_o,
    output logic              rx_irq_o
);
    logic deliver;

    assign deliver = frm_valid_i && (!wake_en_o || frm_addr_i);

    // Update the flags and the data register from host strobes and frame deliveries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_o   <= '0;
            rx_mpb_o    <= 1'b0;
            rx_full_o   <= 1'b0;
            wake_en_o   <= 1'b0;
            frame_err_o <= 1'b0;
            overrun_o   <= 1'b0;
            rx_irq_o    <= 1'b0;
        end else begin
            rx_irq_o <= 1'b0;
            if (full_clr_i) rx_full_o <= 1'b0;
            if (err_clr_i) begin
                frame_err_o <= 1'b0;
                overrun_o   <= 1'b0;
            end
            if (deliver) begin
                if (!frm_stop_ok_i) frame_err_o <= 1'b1;
                if (rx_full_o) begin
                    overrun_o <= 1'b1;
                end else begin
                    rx_data_o <= frm_data_i;
                    rx_mpb_o  <= frm_addr_i;
                    rx_full_o <= 1'b1;
                    rx_irq_o  <= 1'b1;
                end
                if (frm_addr_i) wake_en_o <= 1'b0;
            end
            if (wake_set_i) wake_en_o <= 1'b1;
        end
    end

    // R3: a filtered frame leaves data, full flag and interrupt untouched.
    assert_drop_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && wake_en_o && !frm_addr_i && !full_clr_i && !err_clr_i)
        |=> (!rx_irq_o && $stable(rx_data_o) && $stable(rx_full_o) && $stable(frame_err_o)));

    // R4: an interrupt pulse always comes with the full flag set.
    assert_irq_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |-> rx_full_o);

    // R4: the interrupt is a single-cycle pulse.
    assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |=> !rx_irq_o);

    // R5: an address frame accepted under wake-up clears the flag.
    assert_wake_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && wake_en_o && frm_addr_i && !wake_set_i) |=> !wake_en_o);

    // R8: delivery into a full register raises overrun and keeps the data.
    assert_overrun_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && (!wake_en_o || frm_addr_i) && rx_full_o && !err_clr_i)
        |=> (overrun_o && $stable(rx_data_o) && !rx_irq_o));
endmodule

// File: rtl/mpu_rx_top.sv
// Top level of the address-filtering serial receiver. It chains the
// synchronizer, the framer and the host register block.
// Assumes tick_i is a one-cycle strobe at OVS times the bit rate.
module mpu_rx_top
    import mpu_rx_pkg::*;
#(
    parameter int OVS        = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic              wake_set_i,
    input  logic              full_clr_i,
    input  logic              err_clr_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_mpb_o,
    output logic              rx_full_o,
    output logic              wake_en_o,
    output logic              frame_err_o,
    output logic              overrun_o,
    output logic              rx_irq_o
);
    logic              rx_sync;
    logic              frm_valid;
    logic [DATA_W-1:0] frm_data;
    logic              frm_addr;
    logic              frm_stop_ok;

    mpu_rx_sync #(.STAGES(SYNC_DEPTH)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_sync)
    );

    mpu_rx_framer #(.OVS(OVS)) framer_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .rx_i          (rx_sync),
        .frm_valid_o   (frm_valid),
        .frm_data_o    (frm_data),
        .frm_addr_o    (frm_addr),
        .frm_stop_ok_o (frm_stop_ok)
    );

    mpu_rx_regs regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frm_valid_i   (frm_valid),
        .frm_data_i    (frm_data),
        .frm_addr_i    (frm_addr),
        .frm_stop_ok_i (frm_stop_ok),
        .wake_set_i    (wake_set_i),
        .full_clr_i    (full_clr_i),
        .err_clr_i     (err_clr_i),
        .rx_data_o     (rx_data_o),
        .rx_mpb_o      (rx_mpb_o),
        .rx_full_o     (rx_full_o),
        .wake_en_o     (wake_en_o),
        .frame_err_o   (frame_err_o),
        .overrun_o     (overrun_o),
        .rx_irq_o      (rx_irq_o)
    );
endmodule

// File: tb/mpu_rx_top_tb_top.sv
// Self-checking bench: directed corner cases followed by seeded random frames.
module mpu_rx_top_tb_top;
    localparam int TDIV    = 2;
    localparam int BIT_CLK = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_i = 1'b1;
    logic       tick_i = 1'b0;
    logic       wake_set_i = 1'b0;
    logic       full_clr_i = 1'b0;
    logic       err_clr_i = 1'b0;
    logic [7:0] rx_data_o;
    logic       rx_mpb_o, rx_full_o, wake_en_o, frame_err_o, overrun_o, rx_irq_o;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int div_cnt = 0;
    bit done = 1'b0;

    logic [7:0] e_data;
    logic       e_mpb, e_full, e_wake, e_fe, e_ov;
    int         e_irq;

    always #4 clk = ~clk;

    // Tick generator, one pulse every TDIV clocks.
    always @(posedge clk) begin
        div_cnt <= (div_cnt == TDIV - 1) ? 0 : div_cnt + 1;
        tick_i  <= (div_cnt == TDIV - 1);
    end

    // Count interrupt pulses.
    always @(posedge clk) if (rst_n && rx_irq_o) irq_cnt <= irq_cnt + 1;

    mpu_rx_top dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick_i(tick_i),
        .wake_set_i(wake_set_i), .full_clr_i(full_clr_i), .err_clr_i(err_clr_i),
        .rx_data_o(rx_data_o), .rx_mpb_o(rx_mpb_o), .rx_full_o(rx_full_o),
        .wake_en_o(wake_en_o), .frame_err_o(frame_err_o), .overrun_o(overrun_o),
        .rx_irq_o(rx_irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " data"},  rx_data_o,   e_data);
        chk({req, " mpb"},   rx_mpb_o,    e_mpb);
        chk({req, " full"},  rx_full_o,   e_full);
        chk({req, " wake"},  wake_en_o,   e_wake);
        chk({req, " ferr"},  frame_err_o, e_fe);
        chk({req, " ovr"},   overrun_o,   e_ov);
        chk({req, " irq"},   irq_cnt,     e_irq);
    endtask

    // Reference model of the outcome of one frame (R3..R9).
    function automatic void model_frame(input logic [7:0] d, input logic m, input logic s);
        if (!e_wake || m) begin
            if (!s) e_fe = 1'b1;
            if (e_full) e_ov = 1'b1;
            else begin
                e_data = d; e_mpb = m; e_full = 1'b1; e_irq++;
            end
            if (m) e_wake = 1'b0;
        end
    endfunction

    task automatic host(input logic ws, input logic fc, input logic ec);
        @(negedge clk);
        wake_set_i = ws; full_clr_i = fc; err_clr_i = ec;
        @(negedge clk);
        wake_set_i = 1'b0; full_clr_i = 1'b0; err_clr_i = 1'b0;
        if (fc) e_full = 1'b0;
        if (ec) begin e_fe = 1'b0; e_ov = 1'b0; end
        if (ws) e_wake = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic m, input logic s);
        logic [10:0] bits;
        bits = {s, m, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            rx_i = bits[i];
            repeat (BIT_CLK - 1) @(negedge clk);
        end
        @(negedge clk);
        rx_i = 1'b1;
        repeat (BIT_CLK / 2) @(negedge clk);
        model_frame(d, m, s);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        e_data = 8'h00; e_mpb = 0; e_full = 0; e_wake = 0; e_fe = 0; e_ov = 0; e_irq = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R10 reset");

        // R3: wake-up on, data frame dropped.
        host(1'b1, 1'b0, 1'b0);
        send_frame(8'hA5, 1'b0, 1'b0);
        check_all("R3 drop");
        // R4/R5: ID frame accepted, wake-up cleared.
        send_frame(8'h3C, 1'b1, 1'b1);
        check_all("R4 R5 id");
        // R8: next frame while full causes overrun.
        send_frame(8'h81, 1'b0, 1'b1);
        check_all("R8 overrun");
        // R6/R7: clear full, data frame delivered with mpb 0.
        host(1'b0, 1'b1, 1'b1);
        send_frame(8'h01, 1'b0, 1'b1);
        check_all("R6 R7 data");
        // R9: stop bit low still delivers, sets framing error.
        host(1'b0, 1'b1, 1'b0);
        send_frame(8'hF0, 1'b1, 1'b0);
        check_all("R9 ferr");
        host(1'b0, 1'b0, 1'b1);
        check_all("R9 clear");
        // R2: short low glitch is ignored.
        host(1'b0, 1'b1, 1'b0);
        @(negedge clk); rx_i = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        rx_i = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        check_all("R2 glitch");
        send_frame(8'h5A, 1'b0, 1'b1);
        check_all("R2 R1 after glitch");

        // Random traffic.
        for (int n = 0; n < 60; n++) begin
            logic [7:0] d;
            logic m, s, ws, fc, ec;
            d  = 8'($urandom);
            m  = ($urandom % 4) == 0;
            s  = ($urandom % 8) != 0;
            ws = ($urandom % 5) == 0;
            fc = ($urandom % 3) != 0;
            ec = ($urandom % 4) == 0;
            host(ws, fc, ec);
            send_frame(d, m, s);
            check_all("R1 R6 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule